// File: doc/BRIEF.md
# Arithmetic Logic Unit with Overflow and Equality Flags

This block is the combinational arithmetic and logic unit of a small processor datapath. It reads two operands and a 3-bit operation code in the same cycle and returns a result word. It also returns an overflow flag, which the processor's exception logic consumes, and an equality flag, which branch-if-equal consumes. The operand width is a parameter and defaults to 32 bits.

Every add and subtract goes through one shared adder. For subtract, a per-bit inverting multiplexer feeds the complement of B into the adder and the carry-in is forced to 1, so the adder computes A + ~B + 1. The signed and unsigned variants of add and subtract produce the same result bits. They differ only in the rule that raises overflow. The signed less-than comparison takes the sign of A - B and inverts that sign when the subtraction overflows. The equality flag comes from a bitwise XNOR of the operands that is then AND-reduced, so it does not depend on the adder at all.

A parameter selects between an explicit ripple-carry chain and a single behavioural addition. Both variants have the same ports and produce the same values.

Top module: `alu_ovf`

## Requirements
- R1: Logic operations: opcode 000 returns A AND B, opcode 001 returns A OR B, and opcode 101 returns the bitwise complement of A.
- R2: Addition: opcodes 010 (signed add) and 110 (unsigned add) both return (A + B) mod 2^WIDTH.
- R3: Subtraction: opcodes 011 (signed subtract) and 111 (unsigned subtract) both return (A - B) mod 2^WIDTH.
- R4: For opcode 110, overflow is 1 exactly when A + B >= 2^WIDTH. For opcode 111, overflow is the adder carry-out of A + ~B + 1, which is 1 exactly when A >= B as unsigned numbers.
- R5: For opcodes 010 and 011, overflow is 1 exactly when the exact two's-complement sum or difference lies outside [-2^(WIDTH-1), 2^(WIDTH-1) - 1].
- R6: The overflow output is 0 for opcodes 000, 001, 100 and 101.
- R7: Opcode 100 returns 1 in bit 0 when A < B as two's-complement numbers, and 0 otherwise. The comparison is also correct when A - B overflows. All higher result bits are 0.
- R8: The equality output is 1 exactly when A equals B, whatever the opcode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| op_i | input | 3 | Operation code |
| res_o | output | WIDTH | Result word |
| ovf_o | output | 1 | Overflow flag for the exception logic |
| eq_o | output | 1 | Operand equality flag for branching |

## Verification
A 4-bit instance that uses the ripple adder is driven with every operand pair under every opcode. This sweep separates the signed overflow rule from the unsigned carry rule for each combination of sign bits. It also covers every less-than case in which the difference wraps. A 32-bit instance that uses the behavioural adder is driven with boundary pairs under all opcodes. These pairs are most-negative plus most-negative, most-positive plus one, all-ones plus one, zero minus one, and comparisons of extreme values whose difference overflows. This shows that both adder variants agree with the arithmetic model at the extremes of the range.

// File: rtl/alu_ovf_pkg.sv
package alu_ovf_pkg;

   typedef enum logic [2:0] {
      OP_AND  = 3'b000,
      OP_OR   = 3'b001,
      OP_SADD = 3'b010,
      OP_SSUB = 3'b011,
      OP_SLT  = 3'b100,
      OP_NOTA = 3'b101,
      OP_UADD = 3'b110,
      OP_USUB = 3'b111
   } alu_op_e;

   typedef struct packed {
      logic invert_b;
      logic carry_in;
      logic use_unsigned;
      logic use_signed;
   } alu_ctrl_t;

endpackage

// File: rtl/alu_ovf_ctrl.sv
module alu_ovf_ctrl
   import alu_ovf_pkg::*;
(
   input  alu_op_e   op_i,
   output alu_ctrl_t ctrl_o
);

   logic is_sub;

   always_comb begin
      is_sub = (op_i == OP_SLT) || (op_i == OP_SSUB) || (op_i == OP_USUB);
      ctrl_o.invert_b     = is_sub;
      ctrl_o.carry_in     = is_sub;
      ctrl_o.use_unsigned = (op_i == OP_UADD) || (op_i == OP_USUB);
      ctrl_o.use_signed   = (op_i == OP_SADD) || (op_i == OP_SSUB);
   end

endmodule

// File: rtl/alu_ovf_invmux.sv
module alu_ovf_invmux #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] b_i,
   input  logic             inv_i,
   output logic [WIDTH-1:0] b_o
);

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      assign b_o[i] = inv_i ? ~b_i[i] : b_i[i];
   end

endmodule

// File: rtl/alu_ovf_adder.sv
module alu_ovf_adder #(
   parameter int WIDTH  = 32,
   parameter bit RIPPLE = 1'b1
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic             cin_i,
   output logic [WIDTH-1:0] sum_o,
   output logic             cout_o
);

   if (RIPPLE) begin : g_ripple
      logic [WIDTH:0] carry;
      assign carry[0] = cin_i;
      for (genvar i = 0; i < WIDTH; i++) begin : g_fa
         assign sum_o[i]   = a_i[i] ^ b_i[i] ^ carry[i];
         assign carry[i+1] = (a_i[i] & b_i[i]) | (carry[i] & (a_i[i] ^ b_i[i]));
      end
      assign cout_o = carry[WIDTH];
   end else begin : g_flat
      assign {cout_o, sum_o} = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i};
   end

endmodule

// File: rtl/alu_ovf_flags.sv
module alu_ovf_flags (
   input  logic a_msb_i,
   input  logic b_msb_i,
   input  logic s_msb_i,
   input  logic cout_i,
   input  logic use_unsigned_i,
   input  logic use_signed_i,
   output logic ovf_o,
   output logic lt_o
);

   logic sign_ovf;

   assign sign_ovf = (a_msb_i & b_msb_i & ~s_msb_i) | (~a_msb_i & ~b_msb_i & s_msb_i);
   assign ovf_o    = (use_unsigned_i & cout_i) | (use_signed_i & sign_ovf);
   assign lt_o     = s_msb_i ^ sign_ovf;

endmodule

// File: rtl/alu_ovf_eq.sv
module alu_ovf_eq #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   output logic             eq_o
);

   logic [WIDTH-1:0] same;

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      assign same[i] = ~(a_i[i] ^ b_i[i]);
   end

   assign eq_o = &same;

endmodule

// File: rtl/alu_ovf.sv
module alu_ovf
   import alu_ovf_pkg::*;
#(
   parameter int WIDTH  = 32,
   parameter bit RIPPLE = 1'b1
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic [2:0]       op_i,
   output logic [WIDTH-1:0] res_o,
   output logic             ovf_o,
   output logic             eq_o
);

   localparam int MSB = WIDTH - 1;

   if (WIDTH < 2) begin : g_bad_width
      $error("alu_ovf: WIDTH must be at least 2");
   end

   alu_op_e          op;
   alu_ctrl_t        ctrl;
   logic [WIDTH-1:0] b_add;
   logic [WIDTH-1:0] sum;
   logic             cout;
   logic             lt;

   assign op = alu_op_e'(op_i);

   alu_ovf_ctrl u_ctrl (
      .op_i   (op),
      .ctrl_o (ctrl)
   );

   alu_ovf_invmux #(.WIDTH(WIDTH)) u_invmux (
      .b_i   (b_i),
      .inv_i (ctrl.invert_b),
      .b_o   (b_add)
   );

   alu_ovf_adder #(.WIDTH(WIDTH), .RIPPLE(RIPPLE)) u_adder (
      .a_i    (a_i),
      .b_i    (b_add),
      .cin_i  (ctrl.carry_in),
      .sum_o  (sum),
      .cout_o (cout)
   );

   alu_ovf_flags u_flags (
      .a_msb_i        (a_i[MSB]),
      .b_msb_i        (b_add[MSB]),
      .s_msb_i        (sum[MSB]),
      .cout_i         (cout),
      .use_unsigned_i (ctrl.use_unsigned),
      .use_signed_i   (ctrl.use_signed),
      .ovf_o          (ovf_o),
      .lt_o           (lt)
   );

   alu_ovf_eq #(.WIDTH(WIDTH)) u_eq (
      .a_i  (a_i),
      .b_i  (b_i),
      .eq_o (eq_o)
   );

   always_comb begin
      unique case (op)
         OP_AND:  res_o = a_i & b_i;
         OP_OR:   res_o = a_i | b_i;
         OP_NOTA: res_o = ~a_i;
         OP_SLT:  res_o = {{(WIDTH-1){1'b0}}, lt};
         default: res_o = sum;
      endcase
   end

endmodule

// File: rtl/alu_ovf_chk.sv
module alu_ovf_chk #(
   parameter int WIDTH = 32
) (
   input logic [WIDTH-1:0] a_i,
   input logic [WIDTH-1:0] b_i,
   input logic [2:0]       op_i,
   input logic [WIDTH-1:0] res_o,
   input logic             ovf_o,
   input logic             eq_o
);

   logic [WIDTH:0] usum;
   logic [WIDTH:0] ssum;
   logic [WIDTH:0] sdif;

   assign usum = {1'b0, a_i} + {1'b0, b_i};
   assign ssum = {a_i[WIDTH-1], a_i} + {b_i[WIDTH-1], b_i};
   assign sdif = {a_i[WIDTH-1], a_i} - {b_i[WIDTH-1], b_i};

   always_comb begin
      AST_EQ_MATCH: assert (eq_o == (a_i == b_i)); // R8
      if (op_i == 3'b000 || op_i == 3'b001 || op_i == 3'b101 || op_i == 3'b100) begin
         AST_NO_OVERFLOW: assert (!ovf_o); // R6
      end
      if (op_i == 3'b110) begin
         AST_UADD_CARRY: assert (ovf_o == usum[WIDTH]); // R4
      end
      if (op_i == 3'b111) begin
         AST_USUB_CARRY: assert (ovf_o == (a_i >= b_i)); // R4
      end
      if (op_i == 3'b010) begin
         AST_SADD_RANGE: assert (ovf_o == (ssum[WIDTH] != ssum[WIDTH-1])); // R5
      end
      if (op_i == 3'b011) begin
         AST_SSUB_RANGE: assert (ovf_o == (sdif[WIDTH] != sdif[WIDTH-1])); // R5
      end
      if (op_i == 3'b100) begin
         AST_SLT_ORDER: assert (res_o == {{(WIDTH-1){1'b0}}, ($signed(a_i) < $signed(b_i))}); // R7
      end
   end

endmodule

bind alu_ovf alu_ovf_chk #(.WIDTH(WIDTH)) u_chk (
   .a_i   (a_i),
   .b_i   (b_i),
   .op_i  (op_i),
   .res_o (res_o),
   .ovf_o (ovf_o),
   .eq_o  (eq_o)
);

// File: tb/test_alu_ovf.sv
module test_alu_ovf;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   int total = 0;
   int bad   = 0;

   logic [3:0]  a4, b4, r4;
   logic [2:0]  op4, op32;
   logic        v4, e4, v32, e32;
   logic [31:0] a32, b32, r32;

   alu_ovf #(.WIDTH(4), .RIPPLE(1'b1)) i_alu_ovf (
      .a_i(a4), .b_i(b4), .op_i(op4), .res_o(r4), .ovf_o(v4), .eq_o(e4)
   );

   alu_ovf #(.WIDTH(32), .RIPPLE(1'b0)) i_alu_ovf_w32 (
      .a_i(a32), .b_i(b32), .op_i(op32), .res_o(r32), .ovf_o(v32), .eq_o(e32)
   );

   task automatic chk(string tag, string what, longint act, longint exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   function automatic longint to_s(int w, longint u);
      return (u >= (64'sd1 <<< (w-1))) ? u - (64'sd1 <<< w) : u;
   endfunction

   task automatic ref_model(input int w, input longint a, input longint b, input int op,
                            output longint res, output longint ovf, output longint eq,
                            output string tag);
      longint mask, sa, sb, s, mx, mn;
      mask = (64'sd1 <<< w) - 1;
      sa = to_s(w, a);
      sb = to_s(w, b);
      mx = (64'sd1 <<< (w-1)) - 1;
      mn = -(64'sd1 <<< (w-1));
      ovf = 0;
      eq  = (a == b) ? 1 : 0;
      case (op)
         0: begin res = a & b; tag = "R1"; end
         1: begin res = a | b; tag = "R1"; end
         5: begin res = ~a & mask; tag = "R1"; end
         2: begin s = sa + sb; res = s & mask; ovf = (s > mx || s < mn) ? 1 : 0; tag = "R5"; end
         3: begin s = sa - sb; res = s & mask; ovf = (s > mx || s < mn) ? 1 : 0; tag = "R5"; end
         6: begin res = (a + b) & mask; ovf = ((a + b) > mask) ? 1 : 0; tag = "R4"; end
         7: begin res = (a - b) & mask; ovf = (a >= b) ? 1 : 0; tag = "R4"; end
         default: begin res = (sa < sb) ? 1 : 0; tag = "R7"; end
      endcase
   endtask

   task automatic run(int w, longint a, longint b, int op);
      longint er, eo, ee;
      string  tg, rtag;
      ref_model(w, a, b, op, er, eo, ee, tg);
      @(posedge clk);
      if (w == 4) begin
         a4 = a[3:0]; b4 = b[3:0]; op4 = op[2:0];
      end else begin
         a32 = a[31:0]; b32 = b[31:0]; op32 = op[2:0];
      end
      @(negedge clk);
      rtag = (op == 2 || op == 6) ? "R2" : (op == 3 || op == 7) ? "R3" : tg;
      if (w == 4) begin
         chk(rtag, "result", longint'(r4), er);
         chk((op == 0 || op == 1 || op == 5 || op == 4) ? "R6" : tg, "overflow", longint'(v4), eo);
         chk("R8", "equal", longint'(e4), ee);
      end else begin
         chk(rtag, "result", longint'(r32), er);
         chk((op == 0 || op == 1 || op == 5 || op == 4) ? "R6" : tg, "overflow", longint'(v32), eo);
         chk("R8", "equal", longint'(e32), ee);
      end
   endtask

   longint corner_a [10];
   longint corner_b [10];

   initial begin
      a4 = '0; b4 = '0; op4 = '0;
      a32 = '0; b32 = '0; op32 = '0;
      @(negedge clk);
      chk("R1", "reset-state result", longint'(r4), 0);
      chk("R8", "reset-state equal", longint'(e4), 1);

      for (int op = 0; op < 8; op++)
         for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++)
               run(4, longint'(a), longint'(b), op);

      corner_a = '{64'h80000000, 64'h7fffffff, 64'hffffffff, 64'h0,
                   64'h80000000, 64'h7fffffff, 64'h12345678, 64'h80000000,
                   64'h7fffffff, 64'hffffffff};
      corner_b = '{64'h80000000, 64'h1, 64'h1, 64'h1,
                   64'h1, 64'hffffffff, 64'h12345678, 64'h7fffffff,
                   64'h80000000, 64'hffffffff};
      for (int k = 0; k < 10; k++)
         for (int op = 0; op < 8; op++)
            run(32, corner_a[k], corner_b[k], op);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule